// File: doc/BRIEF.md
# Done-Queue Descriptor Writer

This block sits between a transmit DMA engine and host memory. Each completed transmit descriptor that the engine hands over is written to a done queue through a memory write port. The port carries a burst length with every request. The writer works in one of two ways. In the first, each descriptor is sent as its own one-beat write. In the second, descriptors gather in an eight-entry internal FIFO and leave as multi-beat bursts.

A small control word selects the mode, can force held descriptors out, and picks a threshold code. The block counts the descriptors that memory has accepted. Once that count reaches two to the power of the code, it raises a sticky status flag. Software acknowledges the flag by pulsing a clear input, which resets both the flag and the count.

A write request is held with a fixed length until memory acknowledges it. On the cycles after the acknowledge, the block sends exactly that many data beats, one per cycle, taken from the head of the FIFO.

Top module: `dq_writer`

## Requirements
- R1: Only control bits 3 (burst enable), 4 (flush) and 10:8 (threshold code) hold state. All other bits of `ctrl_rdata` read 0. After reset the control word reads 0x0000, and writing 0xFFFF reads back 0x0718.
- R2: With burst enable at 0, every descriptor produces its own request with `wr_len` = 1. `desc_ready` stays low while that write is still waiting for `wr_ack` or sending its beat.
- R3: With burst enable at 1 and flush at 0, descriptors are held. A request with `wr_len` = 8 is issued as soon as the FIFO holds 8 entries, and fewer held entries cause no request.
- R4: After each accepted request, exactly `wr_len` beats appear on `wr_data` with `wr_beat` high. Across all requests, descriptors leave in the order they were accepted.
- R5: While flush is 1 in burst mode, any held entries are issued as one request whose `wr_len` equals the number held.
- R6: A pending request keeps `wr_req` high and `wr_len` unchanged until `wr_ack` is seen.
- R7: `dq_count` grows only on a cycle where `wr_req` and `wr_ack` are both high, and it grows by `wr_len`. It saturates at 255 and never wraps.
- R8: `dq_flag` rises once `dq_count` is greater than or equal to 2^code (code 0 gives 1, code 7 gives 128). It then stays high until cleared.
- R9: A `dq_clr` pulse sets `dq_count` to 0 and drops `dq_flag`. If an accepted write falls in the same cycle, the count restarts at that write's length.
- R10: If burst enable is cleared while entries are held, those entries leave as one-beat writes in order. No new descriptor is accepted until the FIFO is empty.
- R11: `desc_ready` is low whenever the FIFO holds 8 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word write value |
| ctrl_rdata | output | 16 | Control word readback |
| desc_valid | input | 1 | Descriptor offered by the DMA engine |
| desc_data | input | DW (32) | Descriptor contents |
| desc_ready | output | 1 | Descriptor can be taken this cycle |
| wr_req | output | 1 | Memory write request |
| wr_len | output | 4 | Beats in the requested write (1 to 8) |
| wr_ack | input | 1 | Memory accepts the request |
| wr_beat | output | 1 | Write data beat valid |
| wr_data | output | DW (32) | Write data beat |
| dq_count | output | CW (8) | Accepted descriptor writes since the last clear |
| dq_flag | output | 1 | Sticky threshold-reached flag |
| dq_clr | input | 1 | Clears count and flag |

## Verification
The two functions that can collide are the clear pulse and the counting of an accepted write. The bench stalls memory so that an eight-beat request stays pending on top of a nonzero count. It then raises `dq_clr` and `wr_ack` for the same clock edge. The result is judged by requiring `dq_count` to equal 8, which is neither the old count plus 8 nor zero, and by requiring the flag to be set against an eight-descriptor threshold.

// File: rtl/dq_writer.sv
module dq_writer #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int CW    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ctrl_we,
  input  logic [15:0]                  ctrl_wdata,
  output logic [15:0]                  ctrl_rdata,
  input  logic                         desc_valid,
  input  logic [DW-1:0]                desc_data,
  output logic                         desc_ready,
  output logic                         wr_req,
  output logic [$clog2(DEPTH+1)-1:0]   wr_len,
  input  logic                         wr_ack,
  output logic                         wr_beat,
  output logic [DW-1:0]                wr_data,
  output logic [CW-1:0]                dq_count,
  output logic                         dq_flag,
  input  logic                         dq_clr
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);
  localparam logic [CW:0] CMAX = {1'b0, {CW{1'b1}}};

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_DATA} st_t;

  st_t            st;
  logic           burst_en, flush_en;
  logic [2:0]     code;
  logic [DW-1:0]  mem [DEPTH];
  logic [AW-1:0]  wp, rp;
  logic [LW-1:0]  fill, len_q, left_q;
  logic           push, pop, issue, acc;
  logic [CW:0]    sum, thr;
  logic [CW-1:0]  cnt_nx;

  assign ctrl_rdata = {5'd0, code, 3'd0, flush_en, burst_en, 3'd0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_en <= 1'b0;
      flush_en <= 1'b0;
      code     <= 3'd0;
    end else if (ctrl_we) begin
      burst_en <= ctrl_wdata[3];
      flush_en <= ctrl_wdata[4];
      code     <= ctrl_wdata[10:8];
    end
  end

  assign desc_ready = (fill != LW'(DEPTH)) && (burst_en || (fill == '0 && st == S_IDLE));
  assign push  = desc_valid && desc_ready;
  assign pop   = (st == S_DATA);
  assign issue = (st == S_IDLE) && (fill != '0) &&
                 (!burst_en || flush_en || fill == LW'(DEPTH));

  assign wr_req  = (st == S_REQ);
  assign wr_len  = len_q;
  assign wr_beat = (st == S_DATA);
  assign wr_data = mem[rp];
  assign acc     = wr_req && wr_ack;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= desc_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      wp     <= '0;
      rp     <= '0;
      fill   <= '0;
      len_q  <= '0;
      left_q <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      fill <= fill + LW'(push) - LW'(pop);
      unique case (st)
        S_IDLE: if (issue) begin
          len_q  <= burst_en ? fill : LW'(1);
          left_q <= burst_en ? fill : LW'(1);
          st     <= S_REQ;
        end
        S_REQ:  if (wr_ack) st <= S_DATA;
        S_DATA: begin
          left_q <= left_q - 1'b1;
          if (left_q == LW'(1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sum    = (dq_clr ? '0 : {1'b0, dq_count}) + (acc ? (CW+1)'(len_q) : '0);
  assign cnt_nx = (sum > CMAX) ? CMAX[CW-1:0] : sum[CW-1:0];
  assign thr    = (CW+1)'(1) << code;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq_count <= '0;
      dq_flag  <= 1'b0;
    end else begin
      dq_count <= cnt_nx;
      dq_flag  <= (dq_flag && !dq_clr) || ({1'b0, cnt_nx} >= thr);
    end
  end

  p_len_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (wr_len >= LW'(1) && wr_len <= LW'(DEPTH)));

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_len)));

  p_count_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_clr |=> (dq_count >= $past(dq_count)));

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_flag && !dq_clr) |=> dq_flag);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_clr && !acc) |=> (dq_count == '0 && !dq_flag));

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == LW'(DEPTH)) |-> !push);
endmodule

// File: tb/sim_dq_writer.sv
module sim_dq_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic [15:0] ctrl_rdata;
  logic        desc_valid = 1'b0;
  logic [31:0] desc_data = '0;
  logic        desc_ready;
  logic        wr_req;
  logic [3:0]  wr_len;
  logic        wr_ack;
  logic        wr_beat;
  logic [31:0] wr_data;
  logic [7:0]  dq_count;
  logic        dq_flag;
  logic        dq_clr = 1'b0;
  logic        ack_en = 1'b1;

  always #5 clk = ~clk;
  assign wr_ack = wr_req && ack_en;

  dq_writer u0 (.clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .desc_valid(desc_valid), .desc_data(desc_data),
    .desc_ready(desc_ready), .wr_req(wr_req), .wr_len(wr_len), .wr_ack(wr_ack),
    .wr_beat(wr_beat), .wr_data(wr_data), .dq_count(dq_count), .dq_flag(dq_flag),
    .dq_clr(dq_clr));

  int errs = 0, checks = 0, serial = 0, rq_n = 0, rx_n = 0;
  int rq_len [0:1023];
  logic [31:0] rx [0:1023];

  always @(negedge clk) begin
    if (wr_req && wr_ack && rq_n < 1024) begin rq_len[rq_n] = int'(wr_len); rq_n++; end
    if (wr_beat && rx_n < 1024) begin rx[rx_n] = wr_data; rx_n++; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wr_ctrl(input logic [15:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v; tick(); ctrl_we = 1'b0;
  endtask

  task automatic clear();
    dq_clr = 1'b1; tick(); dq_clr = 1'b0;
  endtask

  task automatic send(input int n);
    for (int k = 0; k < n; k++) begin
      bit rdy;
      int guard = 0;
      desc_valid = 1'b1;
      desc_data  = 32'hA000_0000 + serial;
      do begin
        rdy = desc_ready;
        tick();
        guard++;
      end while (!rdy && guard < 2000);
      serial++;
      desc_valid = 1'b0;
    end
  endtask

  task automatic chk_order(input int rb, input int sb, input int n, input string req);
    int bad = -1;
    for (int i = 0; i < n; i++)
      if (bad < 0 && rx[rb+i] != 32'hA000_0000 + sb + i) bad = i;
    chk(bad < 0 && rx_n - rb == n, req, rx_n - rb, n);
  endtask

  // burst, flush, code, n, requests, count, flag
  localparam logic [26:0] VEC [8] = '{
    {1'b0, 1'b0, 3'd0, 9'd3,  4'd3, 8'd3,  1'b1},
    {1'b0, 1'b0, 3'd3, 9'd5,  4'd5, 8'd5,  1'b0},
    {1'b0, 1'b0, 3'd2, 9'd4,  4'd4, 8'd4,  1'b1},
    {1'b1, 1'b0, 3'd3, 9'd8,  4'd1, 8'd8,  1'b1},
    {1'b1, 1'b0, 3'd4, 9'd16, 4'd2, 8'd16, 1'b1},
    {1'b1, 1'b1, 3'd4, 9'd11, 4'd2, 8'd11, 1'b0},
    {1'b1, 1'b1, 3'd2, 9'd5,  4'd1, 8'd5,  1'b1},
    {1'b0, 1'b0, 3'd1, 9'd3,  4'd3, 8'd3,  1'b1}
  };

  initial begin
    #1_500_000;
    errs++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    chk(ctrl_rdata == 16'h0000, "R1 reset ctrl", int'(ctrl_rdata), 0);
    chk(dq_count == 8'd0, "R7 reset count", int'(dq_count), 0);
    chk(dq_flag == 1'b0, "R8 reset flag", int'(dq_flag), 0);
    chk(wr_req == 1'b0, "R6 reset req", int'(wr_req), 0);
    chk(desc_ready == 1'b1, "R2 reset ready", int'(desc_ready), 1);

    for (int v = 0; v < 8; v++) begin
      logic [26:0] e;
      int rqb, rxb, sb, n, tot;
      string tg;
      e = VEC[v];
      n = int'(e[21:13]);
      tg = e[25] ? "R5" : (e[26] ? "R3" : "R2");
      clear();
      wr_ctrl({5'd0, e[24:22], 4'd0, e[26], 3'd0});
      rqb = rq_n; rxb = rx_n; sb = serial;
      send(n);
      tick(40);
      if (e[25]) begin
        wr_ctrl({5'd0, e[24:22], 3'd0, 1'b1, e[26], 3'd0});
        tick(20);
        wr_ctrl({5'd0, e[24:22], 4'd0, e[26], 3'd0});
        tick(10);
      end
      chk(rq_n - rqb == int'(e[12:9]), tg, rq_n - rqb, int'(e[12:9]));
      tot = 0;
      for (int i = rqb; i < rq_n; i++) tot += rq_len[i];
      chk(tot == n, "R4 lengths", tot, n);
      chk_order(rxb, sb, n, "R4 order");
      chk(dq_count == e[8:1], "R7 count", int'(dq_count), int'(e[8:1]));
      chk(dq_flag == e[0], "R8 flag", int'(dq_flag), int'(e[0]));
    end

    // R2: single write pending blocks the input
    wr_ctrl(16'h0000);
    clear();
    ack_en = 1'b0;
    send(1);
    tick(3);
    chk(wr_req && wr_len == 4'd1, "R2 single pending", int'(wr_len), 1);
    chk(desc_ready == 1'b0, "R2 ready low", int'(desc_ready), 0);
    ack_en = 1'b1;
    tick(10);
    chk(dq_count == 8'd1, "R7 single counted", int'(dq_count), 1);

    // R11 / R6: full FIFO with stalled memory
    ack_en = 1'b0;
    wr_ctrl(16'h0308);
    send(8);
    tick(3);
    chk(desc_ready == 1'b0, "R11 full not ready", int'(desc_ready), 0);
    chk(wr_req && wr_len == 4'd8, "R3 burst of 8", int'(wr_len), 8);
    tick(5);
    chk(wr_req && wr_len == 4'd8, "R6 held", int'(wr_len), 8);

    // R9: clear and accept in the same cycle
    dq_clr = 1'b1; ack_en = 1'b1;
    tick();
    dq_clr = 1'b0;
    chk(dq_count == 8'd8, "R9 clear with ack", int'(dq_count), 8);
    chk(dq_flag == 1'b1, "R9 flag from ack", int'(dq_flag), 1);
    tick(15);
    clear();
    chk(dq_count == 8'd0 && dq_flag == 1'b0, "R9 clear alone", int'(dq_count), 0);

    // R10: leaving burst mode with entries held
    begin
      int rqb, rxb, sb, ones;
      wr_ctrl(16'h0008);
      rqb = rq_n; rxb = rx_n; sb = serial;
      send(3);
      tick(5);
      chk(rq_n == rqb, "R3 held below 8", rq_n - rqb, 0);
      wr_ctrl(16'h0000);
      send(1);
      tick(20);
      ones = 0;
      for (int i = rqb; i < rq_n; i++) if (rq_len[i] == 1) ones++;
      chk(rq_n - rqb == 4 && ones == 4, "R10 singles", ones, 4);
      chk_order(rxb, sb, 4, "R10 order");
    end

    // R7: saturation
    wr_ctrl(16'h0708);
    clear();
    send(264);
    tick(40);
    chk(dq_count == 8'd255, "R7 saturate", int'(dq_count), 255);
    chk(dq_flag == 1'b1, "R8 code 7", int'(dq_flag), 1);

    // R1: unused control bits
    wr_ctrl(16'hFFFF);
    chk(ctrl_rdata == 16'h0718, "R1 readback", int'(ctrl_rdata), 16'h0718);
    wr_ctrl(16'h0000);
    chk(ctrl_rdata == 16'h0000, "R1 zero", int'(ctrl_rdata), 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule